// File: doc/BRIEF.md
# Framer Interrupt Aggregator

This block merges the interrupt requests of a framer's receive section, its transmit section and an internal one-second timer onto one active-high interrupt line for a microprocessor. Software reaches it through an 8-bit register port with address, write data, read data and separate read and write strobes. Two registers are visible: a block enable register at address 0x04 and a block status register at address 0x05.

Gating happens in two levels. The source level is outside the block: each section delivers a one-cycle request pulse only for causes its own enables already allow. The block level inside can only veto such a request, never create one. A section's status bit is kept by a small state machine with states SEC_IDLE and SEC_WAIT. A request moves it from SEC_IDLE to SEC_WAIT. An acknowledge pulse, which marks a software read of that section's source-level status, moves it back to SEC_IDLE, unless a new request arrives in the same cycle. The one-second status is kept by a machine with states OS_CLEAR and OS_PENDING. A timer tick moves it from OS_CLEAR to OS_PENDING. A read of address 0x05 moves it back to OS_CLEAR, unless a tick arrives in the same cycle. The tick comes from a free-running counter that wraps after TICK_TERMINAL+1 clock cycles.

Top module: `frm_irq_agg`

## Requirements
- R1: After reset all status bits, all enable bits, irq_out and reg_rdata are 0.
- R2: Address 0x04 holds the block enables: bit 7 receive, bit 1 transmit, bit 0 one-second, all read/write; its other bits read as 0. Read data appears on reg_rdata in the cycle after the read strobe and is 0 in cycles with no read.
- R3: A read of address 0x05 returns receive status in bit 7, transmit status in bit 1 and one-second status in bit 0; bits 6 to 2 read as 0.
- R4: A section status bit sets on a request pulse and clears on an acknowledge pulse. Reads of 0x05 do not change it. A request and an acknowledge in the same cycle leave it set.
- R5: The one-second status clears after a read of 0x05. Reads of other addresses leave it set.
- R6: The one-second status sets every TICK_TERMINAL+1 cycles counted from reset, whether or not its enable is set.
- R7: When a tick and a clearing read fall in the same cycle, the read returns the old value and the one-second status ends set.
- R8: irq_out is registered. It is high in the cycle after any status bit is high together with its enable bit, and it falls one cycle after the last such pair ends.
- R9: A block enable of 0 keeps irq_out low for that source while its status is still recorded; setting the enable later raises irq_out.
- R10: Writes to 0x05 or to undefined addresses change nothing, and reads of undefined addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| rx_sect_req | input | 1 | Receive-section request pulse |
| rx_sect_ack | input | 1 | Receive source-level status was read |
| tx_sect_req | input | 1 | Transmit-section request pulse |
| tx_sect_ack | input | 1 | Transmit source-level status was read |
| irq_out | output | 1 | Interrupt to the microprocessor, active high |

## Verification
A request or acknowledge pulse changes the status in the edge where it is sampled, and irq_out follows one edge later. Read data and the read-clear of the one-second bit both take effect at the read edge, and the value appears on reg_rdata one cycle later. The bench drives on falling edges and samples on the following falling edges. It checks irq_out both in the cycle where it must not have moved yet and in the cycle after. A scoreboard queue pairs each read with its expected byte, and the one-second bit is predicted from a cycle count kept since reset.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_SECT = 2;
    localparam int RX_BIT   = 7;
    localparam int TX_BIT   = 1;
    localparam int OS_BIT   = 0;
    localparam logic [REG_W-1:0] EN_MASK =
        REG_W'((1 << RX_BIT) | (1 << TX_BIT) | (1 << OS_BIT));

    typedef enum logic {SEC_IDLE, SEC_WAIT} sect_state_e;
    typedef enum logic {OS_CLEAR, OS_PENDING} os_state_e;
endpackage

// File: rtl/frm_irq_tick.sv
module frm_irq_tick #(
    parameter int TERMINAL = 249,
    parameter int CNT_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(TERMINAL);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);
    p_single_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/frm_irq_sect.sv
module frm_irq_sect
    import frm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic pending
);
    sect_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEC_IDLE: if (req)         state_d = SEC_WAIT;
            SEC_WAIT: if (ack && !req) state_d = SEC_IDLE;
            default:                   state_d = SEC_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == SEC_WAIT);
    end

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pending);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !pending);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !req) |=> $stable(pending));
endmodule

// File: rtl/frm_irq_onesec.sv
module frm_irq_onesec
    import frm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rd_clr,
    output logic pending
);
    os_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_CLEAR:   if (tick)            state_d = OS_PENDING;
            OS_PENDING: if (rd_clr && !tick) state_d = OS_CLEAR;
            default:                         state_d = OS_CLEAR;
        endcase
    end

    always_comb begin
        pending = (state_q == OS_PENDING);
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pending);
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !tick) |=> !pending);
endmodule

// File: rtl/frm_irq_agg.sv
module frm_irq_agg
    import frm_irq_pkg::*;
#(
    parameter int              ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR     = 'h04,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h05,
    parameter int              TICK_TERMINAL = 249
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic              rx_sect_req,
    input  logic              rx_sect_ack,
    input  logic              tx_sect_req,
    input  logic              tx_sect_ack,
    output logic              irq_out
);
    localparam int TICK_W = (TICK_TERMINAL < 2) ? 1 : $clog2(TICK_TERMINAL + 1);
    localparam int SECT_POS [NUM_SECT] = '{RX_BIT, TX_BIT};

    logic [NUM_SECT-1:0] sect_req, sect_ack, sect_pend;
    logic [REG_W-1:0]    en_q, stat_vec, rd_mux;
    logic                tick, os_pend, rd_clr, irq_q;

    assign sect_req = {tx_sect_req, rx_sect_req};
    assign sect_ack = {tx_sect_ack, rx_sect_ack};
    assign rd_clr   = reg_rd && (reg_addr == STAT_ADDR);

    frm_irq_tick #(.TERMINAL(TICK_TERMINAL), .CNT_W(TICK_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    frm_irq_onesec u_onesec (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_clr(rd_clr), .pending(os_pend)
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        frm_irq_sect u_sect (
            .clk(clk), .rst_n(rst_n), .req(sect_req[s]), .ack(sect_ack[s]),
            .pending(sect_pend[s])
        );
    end

    always_comb begin
        stat_vec = '0;
        for (int s = 0; s < NUM_SECT; s++) stat_vec[SECT_POS[s]] = sect_pend[s];
        stat_vec[OS_BIT] = os_pend;
    end

    always_comb begin
        if (reg_addr == EN_ADDR)        rd_mux = en_q;
        else if (reg_addr == STAT_ADDR) rd_mux = stat_vec;
        else                            rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            reg_rdata <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == EN_ADDR) en_q <= reg_wdata & EN_MASK;
            reg_rdata <= reg_rd ? rd_mux : '0;
            irq_q     <= |(stat_vec & en_q);
        end
    end

    assign irq_out = irq_q;

    p_veto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_out);
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~EN_MASK) == '0);
    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

// File: tb/frm_irq_agg_tb_top.sv
`timescale 1ns/1ps
module frm_irq_agg_tb_top;
    localparam int T = 49;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic       rx_req = 1'b0, rx_ack = 1'b0, tx_req = 1'b0, tx_ack = 1'b0;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frm_irq_agg #(.TICK_TERMINAL(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rx_sect_req(rx_req), .rx_sect_ack(rx_ack),
        .tx_sect_req(tx_req), .tx_sect_ack(tx_ack), .irq_out(irq_out)
    );

    // Prediction of the one-second bit: set every T+1 cycles from reset, cleared by a status read.
    int ecnt;
    bit m_os;
    always @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= 0;
            m_os <= 1'b0;
        end else begin
            ecnt <= (ecnt == T) ? 0 : ecnt + 1;
            if (ecnt == T)                        m_os <= 1'b1;
            else if (reg_rd && reg_addr == 8'h05) m_os <= 1'b0;
        end
    end

    // Scoreboard
    int    exp_q[$];
    string tag_q[$];
    int    pend_exp;
    bit    pend_model;
    string pend_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && reg_rd) begin
            exp_q.push_back((pend_model && reg_addr == 8'h05) ? (pend_exp | int'(m_os)) : pend_exp);
            tag_q.push_back(pend_tag);
        end
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(reg_rdata == 8'(e), t, reg_rdata, e);
        end
    end

    // Driver tasks: called at a falling edge, return at the next one.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input bit model, input string tag);
        reg_addr = a; reg_rd = 1'b1;
        pend_exp = exp; pend_model = model; pend_tag = tag;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input bit rq, input bit ra, input bit tq, input bit ta);
        rx_req = rq; rx_ack = ra; tx_req = tq; tx_ack = ta;
        @(negedge clk);
        rx_req = 0; rx_ack = 0; tx_req = 0; tx_ack = 0;
    endtask

    task automatic irq_is(input bit exp, input string tag);
        chk(irq_out == exp, tag, irq_out, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_is(0, "R1 irq after reset");
        chk(reg_rdata == 8'h00, "R1 rdata after reset", reg_rdata, 0);
        rd(8'h04, 8'h00, 0, "R1 enable reset");
        rd(8'h05, 8'h00, 0, "R1 status reset");
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R2 rdata idle", reg_rdata, 0);

        // R2 enable register
        wr(8'h04, 8'hFF);
        rd(8'h04, 8'h83, 0, "R2 enable write ones");
        wr(8'h04, 8'h00);
        rd(8'h04, 8'h00, 0, "R2 enable write zeros");

        // R10 ignored writes, undefined reads
        wr(8'h05, 8'hFF);
        rd(8'h05, 8'h00, 1, "R10 status write ignored");
        wr(8'h33, 8'hFF);
        rd(8'h04, 8'h00, 0, "R10 undefined write ignored");
        rd(8'h33, 8'h00, 0, "R10 undefined read");

        // R3/R4/R8 receive section
        wr(8'h04, 8'h82);
        pulse(1, 0, 0, 0);
        irq_is(0, "R8 irq not yet");
        @(negedge clk);
        irq_is(1, "R8 irq one cycle after status");
        rd(8'h05, 8'h80, 1, "R3 rx status bit 7");
        rd(8'h05, 8'h80, 1, "R4 rx not cleared by read");
        irq_is(1, "R4 irq held after read");
        pulse(0, 1, 0, 0);
        irq_is(1, "R8 irq falls one cycle late");
        @(negedge clk);
        irq_is(0, "R8 irq low after ack");
        rd(8'h05, 8'h00, 1, "R4 rx cleared by ack");

        // transmit section, set wins
        pulse(0, 0, 1, 0);
        rd(8'h05, 8'h02, 1, "R3 tx status bit 1");
        pulse(0, 0, 1, 1);
        rd(8'h05, 8'h02, 1, "R4 tx request beats ack");
        pulse(0, 0, 0, 1);
        rd(8'h05, 8'h00, 1, "R4 tx cleared");

        // R9 veto
        wr(8'h04, 8'h02);
        pulse(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        irq_is(0, "R9 rx vetoed");
        rd(8'h05, 8'h80, 1, "R9 rx recorded while vetoed");
        wr(8'h04, 8'h80);
        irq_is(0, "R9 irq after enable not yet");
        @(negedge clk);
        irq_is(1, "R9 irq after enable");
        pulse(0, 1, 0, 0);
        wr(8'h04, 8'h00);

        // R6 status sets while disabled; R5 clearing
        rd(8'h05, 8'h00, 1, "R5 flush");
        @(negedge clk);
        while (!m_os) @(negedge clk);
        rd(8'h05, 8'h01, 0, "R6 set while disabled");
        while (!m_os) @(negedge clk);
        rd(8'h04, 8'h00, 0, "R5 other read");
        rd(8'h05, 8'h01, 0, "R5 still set after other read");
        rd(8'h05, 8'h00, 0, "R5 cleared by status read");

        // one-second interrupt
        wr(8'h04, 8'h01);
        while (!m_os) @(negedge clk);
        irq_is(0, "R6 irq not yet");
        @(negedge clk);
        irq_is(1, "R6 one-second irq");
        rd(8'h05, 8'h01, 0, "R5 read pending");
        irq_is(1, "R8 irq lag on clear");
        @(negedge clk);
        irq_is(0, "R5 irq low after read-clear");

        // R7 collision
        while (ecnt != T) @(negedge clk);
        rd(8'h05, 8'h00, 0, "R7 read returns old value");
        rd(8'h05, 8'h01, 0, "R7 tick wins over clear");

        wr(8'h04, 8'h00);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule